// File: doc/BRIEF.md
# Keyboard Scan Code Event Interpreter

This block sits behind a serial keyboard receiver and turns its stream of 8-bit scan code bytes into key events. Each byte arrives with a one-cycle valid strobe. A plain code is reported as a key press. The release prefix byte (F0 hex) produces no event of its own. It arms a pending flag, so the next code is reported as a release and the flag then clears.

Across these byte events the block keeps three pieces of state. The first is a shift-held bit, driven by press and release events of the two shift keys. Software or a later stage needs it to tell upper case from lower case, because the letter codes are the same in both cases. The second is a decimal digit register, which loads the numeral 0 to 9 when a digit key is pressed. The third is a copy of the last raw byte, including prefix bytes, for driving a row of LEDs. Extended E0-prefixed codes get no special treatment and are reported as ordinary events.

All outputs come from registers. They change on the clock edge that samples the valid byte and are read in the cycle after it.

Top module: `scan_event_decoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `evt_valid`, `evt_release`, `shift_held`, `digit_valid`, `digit_value` and `last_byte` are all zero. The pending release flag is clear.
- R2: A valid byte other than F0 hex, with no release pending, gives a one-cycle pulse on `evt_valid` in the next cycle. In that cycle `evt_release` is 0 and `evt_code` equals the byte.
- R3: A valid F0 hex byte gives no event and arms the release flag. The next valid non-F0 byte gives an event with `evt_release` = 1, and the flag is then cleared. Repeated F0 bytes keep the flag armed.
- R4: A press event of code 12 hex (left shift) or 59 hex (right shift) sets `shift_held` in the next cycle. A release event of either code clears it. No other byte changes it.
- R5: A press event of a digit key loads `digit_value` with its numeral and sets `digit_valid` in the next cycle. The codes for digits 0 to 9, in order, are 45, 16, 1E, 26, 25, 2E, 36, 3D, 3E and 46 hex.
- R6: Release events, F0 bytes and press events of non-digit codes leave `digit_value` and `digit_valid` unchanged.
- R7: Every valid byte, F0 included, is copied to `last_byte` in the next cycle.
- R8: In a cycle with `byte_valid` low, `evt_valid` is 0 in the next cycle, and the shift, digit, pending and last-byte state hold their values.
- R9: The byte E0 hex is handled as an ordinary code. It produces a press or release event carrying E0, and it does not touch the pending flag's meaning for the byte that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | One-cycle strobe marking a received byte |
| byte_in | input | 8 | Received scan code byte |
| evt_valid | output | 1 | One-cycle key event pulse |
| evt_release | output | 1 | The event is a key release |
| evt_code | output | 8 | Scan code of the event |
| shift_held | output | 1 | A shift key is held |
| digit_value | output | 4 | Numeral of the last digit key pressed |
| digit_valid | output | 1 | `digit_value` holds a numeral |
| last_byte | output | 8 | Last valid byte received |

## Verification
Releasing a shift key is the sharpest overlap. In a single cycle the pending flag clears, a release event is emitted and `shift_held` drops, while `last_byte` takes the shift code. The bench forces this with directed shift press/letter/shift release/letter release sequences. It also sends back-to-back bytes with no idle cycle between F0 and its code. A bench model updates the expected pending, shift and digit state per byte, and every output is compared in each cycle. The constrained random phase then mixes digit codes, shift codes, F0, E0 and other bytes with idle gaps, so that a digit release can land just after a shift release.

// File: rtl/scan_pkg.sv
package scan_pkg;
   localparam int SCAN_W  = 8;
   localparam int NUM_W   = 4;

   typedef struct packed {
      logic             hit;
      logic [NUM_W-1:0] num;
   } digit_hit_t;

   // maps a digit key make code to its numeral
   function automatic digit_hit_t digit_lookup(input logic [SCAN_W-1:0] c);
      digit_hit_t r;
      r.hit = 1'b1;
      unique case (c)
         8'h45: r.num = 4'd0;
         8'h16: r.num = 4'd1;
         8'h1E: r.num = 4'd2;
         8'h26: r.num = 4'd3;
         8'h25: r.num = 4'd4;
         8'h2E: r.num = 4'd5;
         8'h36: r.num = 4'd6;
         8'h3D: r.num = 4'd7;
         8'h3E: r.num = 4'd8;
         8'h46: r.num = 4'd9;
         default: begin
            r.hit = 1'b0;
            r.num = '0;
         end
      endcase
      return r;
   endfunction
endpackage

// File: rtl/scan_prefix_track.sv
module scan_prefix_track #(
   parameter int                CODE_W = 8,
   parameter logic [CODE_W-1:0] BRK    = 8'hF0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [CODE_W-1:0] in_byte,
   output logic              brk_pend,
   output logic              evt_valid,
   output logic              evt_release,
   output logic [CODE_W-1:0] evt_code
);
   logic is_prefix;
   logic is_code;

   assign is_prefix = in_valid && (in_byte == BRK);
   assign is_code   = in_valid && (in_byte != BRK);

   always_ff @(posedge clk) begin
      if (rst) begin
         brk_pend    <= 1'b0;
         evt_valid   <= 1'b0;
         evt_release <= 1'b0;
         evt_code    <= '0;
      end else begin
         evt_valid <= is_code;
         if (is_prefix) begin
            brk_pend <= 1'b1;
         end else if (is_code) begin
            brk_pend    <= 1'b0;
            evt_release <= brk_pend;
            evt_code    <= in_byte;
         end
      end
   end

   // R3
   prefix_arm_chk: assert property (@(posedge clk) disable iff (rst)
      is_prefix |=> (brk_pend && !evt_valid));
   // R3
   release_tag_chk: assert property (@(posedge clk) disable iff (rst)
      (is_code && brk_pend) |=> (evt_valid && evt_release && !brk_pend));
   // R2
   press_tag_chk: assert property (@(posedge clk) disable iff (rst)
      (is_code && !brk_pend) |=> (evt_valid && !evt_release && evt_code == $past(in_byte)));
   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!evt_valid && $stable(brk_pend)));
endmodule

// File: rtl/scan_shift_track.sv
module scan_shift_track #(
   parameter int                CODE_W      = 8,
   parameter logic [CODE_W-1:0] LSHIFT      = 8'h12,
   parameter logic [CODE_W-1:0] RSHIFT      = 8'h59,
   parameter bit                SPLIT_SHIFT = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              code_stb,
   input  logic              brk_pend,
   input  logic [CODE_W-1:0] code,
   output logic              shift_held
);
   logic hit_l;
   logic hit_r;

   assign hit_l = code_stb && (code == LSHIFT);
   assign hit_r = code_stb && (code == RSHIFT);

   generate
      if (SPLIT_SHIFT) begin : g_split
         logic held_l;
         logic held_r;
         always_ff @(posedge clk) begin
            if (rst) begin
               held_l <= 1'b0;
               held_r <= 1'b0;
            end else begin
               if (hit_l) held_l <= !brk_pend;
               if (hit_r) held_r <= !brk_pend;
            end
         end
         assign shift_held = held_l || held_r;
      end else begin : g_single
         logic held;
         always_ff @(posedge clk) begin
            if (rst)                held <= 1'b0;
            else if (hit_l || hit_r) held <= !brk_pend;
         end
         assign shift_held = held;
      end
   endgenerate

   // R4
   shift_set_chk: assert property (@(posedge clk) disable iff (rst)
      ((hit_l || hit_r) && !brk_pend) |=> shift_held);
   // R4
   shift_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !(hit_l || hit_r) |=> $stable(shift_held));
endmodule

// File: rtl/scan_digit_latch.sv
module scan_digit_latch
   import scan_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter int DIG_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              code_stb,
   input  logic              brk_pend,
   input  logic [CODE_W-1:0] code,
   output logic [DIG_W-1:0]  digit_value,
   output logic              digit_valid
);
   digit_hit_t look;
   logic       load;

   assign look = digit_lookup(code[SCAN_W-1:0]);
   assign load = code_stb && !brk_pend && look.hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         digit_value <= '0;
         digit_valid <= 1'b0;
      end else if (load) begin
         digit_value <= DIG_W'(look.num);
         digit_valid <= 1'b1;
      end
   end

   // R6
   digit_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(code_stb && !brk_pend) |=> ($stable(digit_value) && $stable(digit_valid)));
   // R5
   digit_flag_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> digit_valid);
endmodule

// File: rtl/scan_event_decoder.sv
module scan_event_decoder #(
   parameter int         CODE_W      = 8,
   parameter int         DIG_W       = 4,
   parameter logic [7:0] BRK_CODE    = 8'hF0,
   parameter logic [7:0] LSHIFT_CODE = 8'h12,
   parameter logic [7:0] RSHIFT_CODE = 8'h59,
   parameter bit         SPLIT_SHIFT = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              byte_valid,
   input  logic [CODE_W-1:0] byte_in,
   output logic              evt_valid,
   output logic              evt_release,
   output logic [CODE_W-1:0] evt_code,
   output logic              shift_held,
   output logic [DIG_W-1:0]  digit_value,
   output logic              digit_valid,
   output logic [CODE_W-1:0] last_byte
);
   localparam logic [CODE_W-1:0] BRK = CODE_W'(BRK_CODE);

   generate
      if (CODE_W != 8) begin : g_bad_code_w
         $error("scan_event_decoder: CODE_W must be 8");
      end
      if (DIG_W < 4) begin : g_bad_dig_w
         $error("scan_event_decoder: DIG_W must hold 0..9");
      end
   endgenerate

   logic brk_pend;
   logic code_stb;

   assign code_stb = byte_valid && (byte_in != BRK);

   scan_prefix_track #(.CODE_W(CODE_W), .BRK(BRK)) u_prefix (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (byte_valid),
      .in_byte    (byte_in),
      .brk_pend   (brk_pend),
      .evt_valid  (evt_valid),
      .evt_release(evt_release),
      .evt_code   (evt_code)
   );

   scan_shift_track #(
      .CODE_W     (CODE_W),
      .LSHIFT     (CODE_W'(LSHIFT_CODE)),
      .RSHIFT     (CODE_W'(RSHIFT_CODE)),
      .SPLIT_SHIFT(SPLIT_SHIFT)
   ) u_shift (
      .clk       (clk),
      .rst       (rst),
      .code_stb  (code_stb),
      .brk_pend  (brk_pend),
      .code      (byte_in),
      .shift_held(shift_held)
   );

   scan_digit_latch #(.CODE_W(CODE_W), .DIG_W(DIG_W)) u_digit (
      .clk        (clk),
      .rst        (rst),
      .code_stb   (code_stb),
      .brk_pend   (brk_pend),
      .code       (byte_in),
      .digit_value(digit_value),
      .digit_valid(digit_valid)
   );

   always_ff @(posedge clk) begin
      if (rst)             last_byte <= '0;
      else if (byte_valid) last_byte <= byte_in;
   end

   // R7
   last_capture_chk: assert property (@(posedge clk) disable iff (rst)
      byte_valid |=> (last_byte == $past(byte_in)));
   // R8
   last_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !byte_valid |=> $stable(last_byte));
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (!evt_valid && !shift_held && !digit_valid && last_byte == '0));
endmodule

// File: tb/sim_scan_event_decoder.sv
module sim_scan_event_decoder;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       byte_valid = 1'b0;
   logic [7:0] byte_in = '0;
   logic       evt_valid, evt_release, shift_held, digit_valid;
   logic [7:0] evt_code, last_byte;
   logic [3:0] digit_value;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model state
   bit       m_pend = 0, m_shift = 0, m_dv = 0;
   bit [3:0] m_dval = 0;
   bit [7:0] m_last = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scan_event_decoder u0 (
      .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
      .evt_valid(evt_valid), .evt_release(evt_release), .evt_code(evt_code),
      .shift_held(shift_held), .digit_value(digit_value),
      .digit_valid(digit_valid), .last_byte(last_byte)
   );

   function automatic int num_of(input bit [7:0] c);
      case (c)
         8'h45: return 0;  8'h16: return 1;  8'h1E: return 2;
         8'h26: return 3;  8'h25: return 4;  8'h2E: return 5;
         8'h36: return 6;  8'h3D: return 7;  8'h3E: return 8;
         8'h46: return 9;
         default: return -1;
      endcase
   endfunction

   function automatic bit [7:0] digit_code(input int n);
      case (n)
         0: return 8'h45; 1: return 8'h16; 2: return 8'h1E; 3: return 8'h26;
         4: return 8'h25; 5: return 8'h2E; 6: return 8'h36; 7: return 8'h3D;
         8: return 8'h3E; default: return 8'h46;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // drive one cycle at a falling edge, check at the next falling edge
   task automatic step(input bit v, input bit [7:0] b);
      bit e_evt, e_rel;
      int n;
      e_evt = v && (b != 8'hF0);
      e_rel = e_evt && m_pend;
      n = num_of(b);
      if (v) m_last = b;
      if (v && b == 8'hF0) m_pend = 1;
      else if (e_evt) begin
         if (b == 8'h12 || b == 8'h59) m_shift = !m_pend;
         if (!m_pend && n >= 0) begin
            m_dval = 4'(n);
            m_dv = 1;
         end
         m_pend = 0;
      end
      byte_valid = v;
      byte_in = b;
      @(negedge clk);
      if (!v) chk("R8 idle evt_valid", 32'(evt_valid), 0);
      else if (b == 8'hF0) chk("R3 prefix no event", 32'(evt_valid), 0);
      else begin
         chk("R2 evt_valid", 32'(evt_valid), 1);
         chk(e_rel ? "R3 release flag" : "R2 press flag", 32'(evt_release), 32'(e_rel));
         chk(b == 8'hE0 ? "R9 E0 code" : "R2 evt_code", 32'(evt_code), 32'(b));
      end
      chk("R4 shift_held", 32'(shift_held), 32'(m_shift));
      chk("R5 digit_value", 32'(digit_value), 32'(m_dval));
      chk("R6 digit_valid", 32'(digit_valid), 32'(m_dv));
      chk("R7 last_byte", 32'(last_byte), 32'(m_last));
   endtask

   task automatic press(input bit [7:0] c);
      step(1, c);
   endtask

   task automatic release_key(input bit [7:0] c);
      step(1, 8'hF0);
      step(1, c);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 evt_valid", 32'(evt_valid), 0);
      chk("R1 shift_held", 32'(shift_held), 0);
      chk("R1 digit_valid", 32'(digit_valid), 0);
      chk("R1 digit_value", 32'(digit_value), 0);
      chk("R1 last_byte", 32'(last_byte), 0);
      rst = 1'b0;
      step(0, 8'h00);
      // R1: byte after reset is a press, so the prefix flag started clear
      step(1, 8'h1C);
      // shift A sequence, R4 with R3
      press(8'h12); press(8'h1C); release_key(8'h12); release_key(8'h1C);
      // right shift, R4
      press(8'h59); step(0, 8'h00); release_key(8'h59);
      // every digit, R5 and R6
      for (int i = 0; i < 10; i++) begin
         press(digit_code(i));
         release_key(digit_code((i + 3) % 10));
      end
      // repeated prefix, R3
      step(1, 8'hF0); step(1, 8'hF0); step(0, 8'h00); step(1, 8'h12);
      press(8'h16);
      // E0 passthrough, R9
      press(8'hE0); press(8'h75);
      step(1, 8'hE0); step(1, 8'hF0); step(1, 8'h75);
      // shift release in same cycle as digit hold, then digit after
      press(8'h12); press(8'h26); release_key(8'h12); release_key(8'h26);
      // reset mid-stream, R1
      step(1, 8'hF0);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1 reset evt_valid", 32'(evt_valid), 0);
      chk("R1 reset digit_valid", 32'(digit_valid), 0);
      chk("R1 reset last_byte", 32'(last_byte), 0);
      rst = 1'b0;
      m_pend = 0; m_shift = 0; m_dv = 0; m_dval = 0; m_last = 0;
      step(1, 8'h45);
      // constrained random mix
      for (int k = 0; k < 3000; k++) begin
         int sel;
         bit [7:0] b;
         sel = int'($urandom_range(0, 9));
         case (sel)
            0, 1: b = digit_code(int'($urandom_range(0, 9)));
            2:    b = 8'h12;
            3:    b = 8'h59;
            4, 5: b = 8'hF0;
            6:    b = 8'hE0;
            default: b = 8'($urandom);
         endcase
         step($urandom_range(0, 3) != 0, b);
      end
      byte_valid = 0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule